// File: doc/BRIEF.md
# Flash Status Register with Sticky Errors

This block holds the 8-bit status word that the write state machine of a flash-style command interface exposes to the host. Three bits mirror level signals from the state machine (ready, erase suspended, program suspended) and follow them in both directions. Four error bits latch on single-cycle event pulses from the state machine. Only a host clear command (byte 0x50 on the command strobe) or a reset drops them. Bit 0 is unused and reads zero.

A clear must not come too soon after an erase or program error has been flagged. Every event that sets bit 5 or bit 4 starts a hold window of `HOLD_CYC` clock cycles. The default of 3000 cycles is 15 µs at 200 MHz. A clear that arrives inside that window is ignored, and it raises a separate sticky `early_clr` flag. The command strobe is a plain one-cycle qualifier and has no back-pressure: any byte other than 0x50 is ignored. The block works the same whatever the program-voltage status is.

Top module: `flash_status_reg`

## Requirements
- R1: After reset `status` is 0x00 and `early_clr` is 0. The hold window is idle, so a 0x50 clear issued right after reset is accepted and leaves `early_clr` at 0.
- R2: `status[7]`, `status[6]` and `status[2]` equal `wsm_ready`, `wsm_erase_susp` and `wsm_prog_susp` as sampled at the previous clock edge. They rise and fall with those inputs, and a clear command does not change them.
- R3: A pulse sampled at an edge sets its sticky bit from that edge on: `ev_erase_err` sets bit 5, `ev_prog_err` sets bit 4, `ev_vpp_err` sets bit 3 and `ev_lock_err` sets bit 1. The bit stays set until an accepted clear or a reset.
- R4: An `ev_seq_err` pulse sets bit 5 and bit 4 at the same edge. Bit 7 keeps reporting `wsm_ready`.
- R5: When `cmd_valid` is high with `cmd_byte` equal to 0x50 and the clear is accepted, bits 5, 4, 3 and 1 are zero after that edge. When `cmd_valid` is high with any other byte, `status` and `early_clr` do not change.
- R6: An edge that samples `ev_erase_err`, `ev_prog_err` or `ev_seq_err` restarts the hold window. A clear sampled k edges later is accepted only if k >= `HOLD_CYC`.
- R7: A clear sampled inside the hold window leaves every status bit as it was and sets `early_clr` after that edge. `early_clr` stays set until an accepted clear or a reset.
- R8: Setting wins over clearing. An error event sampled at the same edge as an accepted clear leaves its bit set.
- R9: A suspended erase that resumes does not remove an error latched during the suspend. When `wsm_erase_susp` falls, bits 5 and 4 stay set.
- R10: `status[0]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; clears the register |
| cmd_valid | input | 1 | Host command strobe, one cycle per byte |
| cmd_byte | input | 8 | Host command byte; 0x50 means clear |
| wsm_ready | input | 1 | State machine ready level (bit 7) |
| wsm_erase_susp | input | 1 | Erase suspended level (bit 6) |
| wsm_prog_susp | input | 1 | Program suspended level (bit 2) |
| ev_erase_err | input | 1 | Erase error pulse (bit 5) |
| ev_prog_err | input | 1 | Program error pulse (bit 4) |
| ev_vpp_err | input | 1 | Program-voltage error pulse (bit 3) |
| ev_lock_err | input | 1 | Locked-block error pulse (bit 1) |
| ev_seq_err | input | 1 | Command sequence error pulse (bits 5 and 4) |
| status | output | 8 | Status register value |
| early_clr | output | 1 | Sticky flag: a clear was refused inside the hold window |

## Verification
The assertions check these rules on every cycle:
- Live bits track their inputs with one cycle of delay.
- An event always leaves its sticky bit set, including against a same-cycle clear.
- Sticky bits and `early_clr` only fall on an accepted clear.
- The hold counter runs only while bit 5 or bit 4 is set.
- A refused clear always raises `early_clr`.

Only the bench's scenarios show the rest:
- The exact cycle at which a clear becomes acceptable for each distance from the error.
- That every non-clear byte is ignored.
- That an error stays latched when a suspended erase resumes.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;
  localparam logic [7:0] OP_CLEAR = 8'h50;

  localparam int B_READY   = 7;
  localparam int B_ESUSP   = 6;
  localparam int B_ERASE   = 5;
  localparam int B_PROG    = 4;
  localparam int B_VPP     = 3;
  localparam int B_PSUSP   = 2;
  localparam int B_LOCK    = 1;

  localparam int N_LIVE   = 3;
  localparam int N_STICKY = 4;

  // sticky slot order inside the sticky bank
  localparam int S_LOCK  = 0;
  localparam int S_VPP   = 1;
  localparam int S_PROG  = 2;
  localparam int S_ERASE = 3;

  typedef struct packed {
    logic seq;
    logic erase;
    logic prog;
    logic vpp;
    logic lock;
  } wsm_evt_t;
endpackage

// File: rtl/fsr_live_bits.sv
module fsr_live_bits #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_live
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o[i] <= 1'b0;
      else        q_o[i] <= lvl_i[i];
    end
  end
endmodule

// File: rtl/fsr_sticky_bank.sv
module fsr_sticky_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;
      else if (clr_i)    q_o[i] <= 1'b0;
    end

    // R8: an event always lands, even with a clear in the same cycle
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> q_o[i]);
    // R3: without a clear a latched bit stays latched
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o[i] && !clr_i) |=> q_o[i]);
  end
endmodule

// File: rtl/fsr_clear_guard.sv
module fsr_clear_guard #(
  parameter int HOLD_CYC = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic clr_req_i,
  output logic clr_ok_o,
  output logic busy_o,
  output logic early_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign busy_o   = (cnt_q != '0);
  assign clr_ok_o = clr_req_i && !busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (arm_i)  cnt_q <= LOAD;
    else if (busy_o) cnt_q <= cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     early_o <= 1'b0;
    else if (clr_req_i && busy_o)   early_o <= 1'b1;
    else if (clr_ok_o)              early_o <= 1'b0;
  end

  // R7: a refused clear is always flagged
  p_early_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req_i && busy_o) |=> early_o);
  // R7: the flag only drops on an accepted clear
  p_early_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (early_o && !clr_ok_o) |=> early_o);
endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
  import flash_sr_pkg::*;
#(
  parameter int HOLD_CYC = 3000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic       wsm_ready,
  input  logic       wsm_erase_susp,
  input  logic       wsm_prog_susp,
  input  logic       ev_erase_err,
  input  logic       ev_prog_err,
  input  logic       ev_vpp_err,
  input  logic       ev_lock_err,
  input  logic       ev_seq_err,
  output logic [7:0] status,
  output logic       early_clr
);
  wsm_evt_t            evt;
  logic [N_STICKY-1:0] sticky_set, sticky_q;
  logic [N_LIVE-1:0]   live_q;
  logic                clr_req, clr_ok, arm, busy;

  assign evt = '{seq: ev_seq_err, erase: ev_erase_err, prog: ev_prog_err,
                 vpp: ev_vpp_err, lock: ev_lock_err};

  assign clr_req = cmd_valid && (cmd_byte == OP_CLEAR);
  assign arm     = evt.erase || evt.prog || evt.seq;

  always_comb begin
    sticky_set          = '0;
    sticky_set[S_LOCK]  = evt.lock;
    sticky_set[S_VPP]   = evt.vpp;
    sticky_set[S_PROG]  = evt.prog  || evt.seq;
    sticky_set[S_ERASE] = evt.erase || evt.seq;
  end

  fsr_live_bits #(.N(N_LIVE)) u_live (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i ({wsm_ready, wsm_erase_susp, wsm_prog_susp}),
    .q_o   (live_q)
  );

  fsr_sticky_bank #(.N(N_STICKY)) u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (sticky_set),
    .clr_i (clr_ok),
    .q_o   (sticky_q)
  );

  fsr_clear_guard #(.HOLD_CYC(HOLD_CYC)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm_i     (arm),
    .clr_req_i (clr_req),
    .clr_ok_o  (clr_ok),
    .busy_o    (busy),
    .early_o   (early_clr)
  );

  always_comb begin
    status          = '0;
    status[B_READY] = live_q[2];
    status[B_ESUSP] = live_q[1];
    status[B_PSUSP] = live_q[0];
    status[B_ERASE] = sticky_q[S_ERASE];
    status[B_PROG]  = sticky_q[S_PROG];
    status[B_VPP]   = sticky_q[S_VPP];
    status[B_LOCK]  = sticky_q[S_LOCK];
  end

  // R2: live bits mirror the level inputs one cycle later
  p_live_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status[B_READY] == $past(wsm_ready)) &&
             (status[B_ESUSP] == $past(wsm_erase_susp)) &&
             (status[B_PSUSP] == $past(wsm_prog_susp)));
  // R4: a sequence error raises both bit 5 and bit 4
  p_seq_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_seq_err |=> (status[B_ERASE] && status[B_PROG]));
  // R5: an accepted clear with no competing event empties the sticky bits
  p_clear_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ok && (sticky_set == '0)) |=>
      !(status[B_ERASE] || status[B_PROG] || status[B_VPP] || status[B_LOCK]));
  // R6: the hold window only runs while an erase/program error is shown
  p_window_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (status[B_ERASE] || status[B_PROG]));
endmodule

// File: tb/flash_status_reg_bench.sv
`timescale 1ns/1ps
module flash_status_reg_bench;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic rdy = 1'b0, esus = 1'b0, psus = 1'b0;
  logic e_er = 1'b0, e_pg = 1'b0, e_vp = 1'b0, e_lk = 1'b0, e_sq = 1'b0;
  logic [7:0] status;
  logic early_clr;

  always #2.5 clk = ~clk;

  flash_status_reg #(.HOLD_CYC(H)) u_flash_status_reg (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .wsm_ready(rdy), .wsm_erase_susp(esus), .wsm_prog_susp(psus),
    .ev_erase_err(e_er), .ev_prog_err(e_pg), .ev_vpp_err(e_vp),
    .ev_lock_err(e_lk), .ev_seq_err(e_sq),
    .status(status), .early_clr(early_clr));

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference state derived from the requirements
  logic [7:0] m_stat = 8'h00;
  logic       m_early = 1'b0;
  int         m_cnt = 0;

  task automatic check(input string tag, input logic [7:0] s_exp, input logic e_exp);
    n_chk++;
    if (status !== s_exp || early_clr !== e_exp) begin
      n_bad++;
      $display("FAIL %s: status=%02h early=%0b expected status=%02h early=%0b",
               tag, status, early_clr, s_exp, e_exp);
    end
  endtask

  // one cycle: drive at negedge, advance model, check after the edge
  task automatic cyc(input string tag, input logic [4:0] ev, input logic [2:0] lv,
                     input logic cv, input logic [7:0] cb);
    logic req, acc, rej;
    logic [7:0] setm, nxt;
    {e_sq, e_er, e_pg, e_vp, e_lk} = ev;
    {rdy, esus, psus} = lv;
    cmd_valid = cv; cmd_byte = cb;
    req = cv && (cb == 8'h50);
    acc = req && (m_cnt == 0);
    rej = req && (m_cnt != 0);
    setm = 8'h00;
    setm[5] = ev[3] | ev[4];
    setm[4] = ev[2] | ev[4];
    setm[3] = ev[1];
    setm[1] = ev[0];
    nxt = (m_stat & 8'b0011_1010 & ~(acc ? 8'b0011_1010 : 8'h00)) | setm;
    nxt[7] = lv[2]; nxt[6] = lv[1]; nxt[2] = lv[0]; nxt[0] = 1'b0;
    m_stat = nxt;
    if (ev[3] | ev[2] | ev[4]) m_cnt = H - 1;
    else if (m_cnt != 0)       m_cnt = m_cnt - 1;
    m_early = rej ? 1'b1 : (acc ? 1'b0 : m_early);
    @(posedge clk);
    @(negedge clk);
    check(tag, m_stat, m_early);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc("R3", 5'b0, 3'b0, 1'b0, 8'h00);
  endtask

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    check("R1", 8'h00, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 8'h00, 1'b0);
    // R1: clear right after reset is accepted, no early flag
    cyc("R1", 5'b0, 3'b0, 1'b1, 8'h50);
    check("R1", 8'h00, 1'b0);

    // R2 / R10: live bit sweep, with a clear mixed in
    for (int v = 0; v < 16; v++) begin
      cyc("R2", 5'b0, v[2:0], v[3], 8'h50);
      check("R2", {v[2], v[1], 3'b000, v[0], 2'b00}, 1'b0);
      if (status[0] !== 1'b0) begin n_bad++; $display("FAIL R10: bit0=%0b expected 0", status[0]); end
      n_chk++;
    end

    // R3 / R4 / R5: each event alone, then a timely clear
    for (int e = 0; e < 5; e++) begin
      logic [7:0] want;
      cyc("R3", 5'(1 << e), 3'b0, 1'b0, 8'h00);
      case (e)
        0: want = 8'h02;
        1: want = 8'h08;
        2: want = 8'h10;
        3: want = 8'h20;
        default: want = 8'h30;
      endcase
      check(e == 4 ? "R4" : "R3", want, 1'b0);
      idle(H);
      check("R3", want, 1'b0);
      cyc("R5", 5'b0, 3'b0, 1'b1, 8'h50);
      check("R5", 8'h00, 1'b0);
    end

    // R6 / R7: clear distance sweep after a program error
    for (int j = 1; j <= H + 2; j++) begin
      cyc("R6", 5'b00100, 3'b0, 1'b0, 8'h00);
      idle(j - 1);
      cyc("R6", 5'b0, 3'b0, 1'b1, 8'h50);
      check("R6", (j < H) ? 8'h10 : 8'h00, (j < H));
      check("R7", (j < H) ? 8'h10 : 8'h00, (j < H));
      idle(H);
      cyc("R7", 5'b0, 3'b0, 1'b1, 8'h50);
      check("R7", 8'h00, 1'b0);
    end

    // R5: every other byte is ignored with all sticky bits set
    cyc("R5", 5'b01111, 3'b0, 1'b0, 8'h00);
    idle(H);
    for (int b = 0; b < 256; b++) begin
      if (b != 8'h50) cyc("R5", 5'b0, 3'b0, 1'b1, 8'(b));
    end
    check("R5", 8'h3A, 1'b0);
    cyc("R5", 5'b0, 3'b0, 1'b1, 8'h50);
    check("R5", 8'h00, 1'b0);

    // R8: event in the same cycle as an accepted clear wins
    cyc("R8", 5'b00011, 3'b0, 1'b0, 8'h00);
    idle(2);
    cyc("R8", 5'b00001, 3'b0, 1'b1, 8'h50);
    check("R8", 8'h02, 1'b0);
    cyc("R8", 5'b01000, 3'b0, 1'b1, 8'h50);
    check("R8", 8'h20, 1'b0);
    idle(H);
    cyc("R8", 5'b0, 3'b0, 1'b1, 8'h50);

    // R9: sequence error during erase suspend survives the resume
    cyc("R9", 5'b0, 3'b110, 1'b0, 8'h00);
    cyc("R9", 5'b10000, 3'b110, 1'b0, 8'h00);
    check("R9", 8'hF0, 1'b0);
    cyc("R9", 5'b0, 3'b000, 1'b0, 8'h00);
    check("R9", 8'h30, 1'b0);
    cyc("R9", 5'b00100, 3'b000, 1'b0, 8'h00);
    check("R9", 8'h30, 1'b0);
    idle(H);
    cyc("R9", 5'b0, 3'b100, 1'b1, 8'h50);
    check("R9", 8'h80, 1'b0);

    // mixed-pattern sweep against the reference state
    lfsr = 32'hACE1_1234;
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] ev;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ev = (lfsr[15:12] == 4'h0) ? lfsr[4:0] : 5'b0;
      cyc("R6", ev, lfsr[7:5], lfsr[11:8] == 4'h3, 8'h50);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule